// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the internal write sequencer of a NOR-style flash device. Each host write carries an address and a data byte. The decoder reads the low byte of a write as an opcode, or as a payload when a sequence expects one. It tracks which source feeds host reads: array data, identifier data or its own status register. It builds program and block-erase operations from two-write sequences. While an operation runs or is suspended, it drops every opcode that is not legal at that point.

The decoder owns the status register. It issues single-cycle start, suspend and resume requests to the sequencer. The sequencer answers with a completion pulse, a fail flag and a suspended level. Block lock state and the programming-voltage check come in as inputs. Both are evaluated for the block named by the current write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read source is array data (rd_mode_o = 0) and the status register reads 80h.
- R2: In the idle state, FFh selects array reads (mode 0), 70h selects status reads (mode 1) and 90h selects identifier reads (mode 2). Any other opcode outside a sequence changes nothing.
- R3: Writing 40h and then any write starts a program operation. The start request carries erase flag 0 and the second write's address and data. Reads then return status.
- R4: Writing 20h and then D0h starts a block erase. The start request carries erase flag 1 and the address of the D0h write.
- R5: If 20h is followed by any byte other than D0h, status bits 5 and 4 are set. No operation starts and reads return status.
- R6: While a program runs, only 70h, B0h and D0h are accepted. While an erase runs, only 70h is accepted. Every other write leaves read data and requests unchanged.
- R7: B0h during a program issues a suspend request. Once the sequencer reports suspended, status bits 7 and 2 both read 1.
- R8: While suspended, only FFh, 70h, 90h and D0h are accepted. D0h issues a resume request, clears status bit 2 and switches reads to status.
- R9: Status bit 7 reads 0 from the start request until the sequencer's completion pulse. A completion with fail set raises bit 4 for a program and bit 5 for an erase.
- R10: When the second write of a sequence targets a locked block, bit 1 is set. When the programming voltage is out of range, bit 3 is set instead. In both cases no start request is issued.
- R11: Error bits 5, 4, 3 and 1 stay set until a 50h write is accepted, which clears all four.
- R12: At most one of the start, suspend and resume requests is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_addr_i | input | AW | Host write address |
| wr_data_i | input | DW | Host write data; the low byte is the opcode |
| arr_rdata_i | input | DW | Array data for the current read address |
| id_rdata_i | input | DW | Identifier data for the current read address |
| rd_data_o | output | DW | Host read data from the selected source |
| rd_mode_o | output | 2 | Read source: 0 array, 1 status, 2 identifier |
| blk_locked_i | input | 1 | Lock state of the block named by wr_addr_i |
| vpp_ok_i | input | 1 | Programming voltage is within range |
| seq_start_o | output | 1 | Start request pulse to the sequencer |
| seq_erase_o | output | 1 | Operation kind of the last start: 1 erase, 0 program |
| seq_addr_o | output | AW | Target address of the last start |
| seq_data_o | output | DW | Program data of the last start |
| seq_suspend_o | output | 1 | Suspend request pulse |
| seq_resume_o | output | 1 | Resume request pulse |
| seq_done_i | input | 1 | Sequencer completion pulse |
| seq_fail_i | input | 1 | Completion result, valid with seq_done_i |
| seq_suspended_i | input | 1 | Sequencer has halted at a suspend point |

## Verification
Some checks run on every cycle. Each request pulse must follow the correct state: start after a setup state, suspend from a running program, resume from suspension. At most one request may be active at a time. A resume must leave reads on status. Error bits may only drop on a clear command. Whether a given opcode is dropped in a given state can only be shown by the bench's scenarios. The same holds for which read source ends up selected, the exact status byte after lock, voltage and sequence faults, and the completion results. The bench drives these as sequences of writes and sequencer responses, then compares the read data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_RD_STATUS = 8'h70;
  localparam logic [7:0] OP_RD_ID     = 8'h90;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_PGM_SETUP = 8'h40;
  localparam logic [7:0] OP_ERS_SETUP = 8'h20;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_SUSPEND   = 8'hB0;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_ID     = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    ST_READY     = 3'd0,
    ST_PGM_SETUP = 3'd1,
    ST_ERS_SETUP = 3'd2,
    ST_PGM_RUN   = 3'd3,
    ST_ERS_RUN   = 3'd4,
    ST_PGM_SUSP  = 3'd5
  } cmd_state_e;

  typedef struct packed {
    logic seq_err;
    logic pgm_fail;
    logic ers_fail;
    logic vpp_err;
    logic lock_err;
    logic clr;
  } err_ev_t;
endpackage

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          blk_locked_i,
  input  logic          vpp_ok_i,
  input  logic          seq_done_i,
  input  logic          seq_fail_i,
  input  logic          seq_suspended_i,
  output rd_mode_e      mode_o,
  output logic          running_o,
  output logic          suspended_o,
  output logic          seq_start_o,
  output logic          seq_erase_o,
  output logic [AW-1:0] seq_addr_o,
  output logic [DW-1:0] seq_data_o,
  output logic          seq_suspend_o,
  output logic          seq_resume_o,
  output err_ev_t       ev_o
);
  cmd_state_e    st_q, st_d;
  rd_mode_e      mode_q, mode_d;
  logic          pend_q, pend_d;
  logic          start_d, erase_d, susp_d, res_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;
  logic [7:0]    op;

  assign op = wr_data_i[7:0];

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    pend_d  = pend_q;
    start_d = 1'b0;
    erase_d = seq_erase_o;
    addr_d  = seq_addr_o;
    data_d  = seq_data_o;
    susp_d  = 1'b0;
    res_d   = 1'b0;
    ev_o    = '0;
    unique case (st_q)
      ST_READY: if (wr_en_i) begin
        unique case (op)
          OP_RD_ARRAY:  mode_d = MODE_ARRAY;
          OP_RD_STATUS: mode_d = MODE_STATUS;
          OP_RD_ID:     mode_d = MODE_ID;
          OP_CLR_STAT:  ev_o.clr = 1'b1;
          OP_PGM_SETUP: begin st_d = ST_PGM_SETUP; mode_d = MODE_STATUS; end
          OP_ERS_SETUP: begin st_d = ST_ERS_SETUP; mode_d = MODE_STATUS; end
          default: ;
        endcase
      end
      ST_PGM_SETUP: if (wr_en_i) begin
        mode_d = MODE_STATUS;
        if (!vpp_ok_i) begin
          ev_o.vpp_err = 1'b1; st_d = ST_READY;
        end else if (blk_locked_i) begin
          ev_o.lock_err = 1'b1; st_d = ST_READY;
        end else begin
          start_d = 1'b1; erase_d = 1'b0;
          addr_d = wr_addr_i; data_d = wr_data_i;
          st_d = ST_PGM_RUN;
        end
      end
      ST_ERS_SETUP: if (wr_en_i) begin
        mode_d = MODE_STATUS;
        if (op != OP_CONFIRM) begin
          ev_o.seq_err = 1'b1; st_d = ST_READY;
        end else if (!vpp_ok_i) begin
          ev_o.vpp_err = 1'b1; st_d = ST_READY;
        end else if (blk_locked_i) begin
          ev_o.lock_err = 1'b1; st_d = ST_READY;
        end else begin
          start_d = 1'b1; erase_d = 1'b1;
          addr_d = wr_addr_i;
          st_d = ST_ERS_RUN;
        end
      end
      ST_PGM_RUN: begin
        if (seq_done_i) begin
          ev_o.pgm_fail = seq_fail_i;
          pend_d = 1'b0;
          st_d = ST_READY;
        end else begin
          if (pend_q && seq_suspended_i) begin
            st_d = ST_PGM_SUSP; pend_d = 1'b0;
          end
          if (wr_en_i) begin
            unique case (op)
              OP_RD_STATUS: mode_d = MODE_STATUS;
              OP_SUSPEND: begin
                susp_d = 1'b1; pend_d = 1'b1; mode_d = MODE_STATUS;
              end
              OP_CONFIRM: mode_d = MODE_STATUS;
              default: ;
            endcase
          end
        end
      end
      ST_ERS_RUN: begin
        if (seq_done_i) begin
          ev_o.ers_fail = seq_fail_i;
          st_d = ST_READY;
        end else if (wr_en_i && op == OP_RD_STATUS) begin
          mode_d = MODE_STATUS;
        end
      end
      ST_PGM_SUSP: if (wr_en_i) begin
        unique case (op)
          OP_RD_ARRAY:  mode_d = MODE_ARRAY;
          OP_RD_STATUS: mode_d = MODE_STATUS;
          OP_RD_ID:     mode_d = MODE_ID;
          OP_CONFIRM: begin
            res_d = 1'b1; mode_d = MODE_STATUS; st_d = ST_PGM_RUN;
          end
          default: ;
        endcase
      end
      default: st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_READY;
      mode_q        <= MODE_ARRAY;
      pend_q        <= 1'b0;
      seq_start_o   <= 1'b0;
      seq_erase_o   <= 1'b0;
      seq_addr_o    <= '0;
      seq_data_o    <= '0;
      seq_suspend_o <= 1'b0;
      seq_resume_o  <= 1'b0;
    end else begin
      st_q          <= st_d;
      mode_q        <= mode_d;
      pend_q        <= pend_d;
      seq_start_o   <= start_d;
      seq_erase_o   <= erase_d;
      seq_addr_o    <= addr_d;
      seq_data_o    <= data_d;
      seq_suspend_o <= susp_d;
      seq_resume_o  <= res_d;
    end
  end

  assign mode_o      = mode_q;
  assign running_o   = (st_q == ST_PGM_RUN) || (st_q == ST_ERS_RUN);
  assign suspended_o = (st_q == ST_PGM_SUSP);

  assert_start_after_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |-> ($past(st_q) == ST_PGM_SETUP || $past(st_q) == ST_ERS_SETUP));
  assert_erase_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_start_o && seq_erase_o) |-> st_q == ST_ERS_RUN);
  assert_suspend_from_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_suspend_o |-> $past(st_q) == ST_PGM_RUN);
  assert_resume_from_susp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_resume_o |-> ($past(st_q) == ST_PGM_SUSP && mode_q == MODE_STATUS));
  assert_one_request_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({seq_start_o, seq_suspend_o, seq_resume_o}));
endmodule

// File: rtl/fcd_status_reg.sv
module fcd_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_ev_t    ev_i,
  input  logic       running_i,
  input  logic       suspended_i,
  output logic [7:0] status_o
);
  // err_q = {bit5, bit4, bit3, bit1}
  logic [3:0] err_q, err_d;

  always_comb begin
    if (ev_i.clr) err_d = '0;
    else err_d = err_q | {ev_i.seq_err | ev_i.ers_fail,
                          ev_i.seq_err | ev_i.pgm_fail,
                          ev_i.vpp_err,
                          ev_i.lock_err};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= err_d;
  end

  assign status_o = {!running_i, 1'b0, err_q[3], err_q[2], err_q[1],
                     suspended_i, err_q[0], 1'b0};

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.clr |=> ((err_q & $past(err_q)) == $past(err_q)));
  assert_err_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.clr |=> err_q == 4'd0);
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  rd_mode_e      mode_i,
  input  logic [DW-1:0] arr_i,
  input  logic [DW-1:0] id_i,
  input  logic [7:0]    status_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] st_ext;

  always_comb begin
    st_ext      = '0;
    st_ext[7:0] = status_i;
    unique case (mode_i)
      MODE_STATUS: rd_o = st_ext;
      MODE_ID:     rd_o = id_i;
      default:     rd_o = arr_i;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] arr_rdata_i,
  input  logic [DW-1:0] id_rdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic [1:0]    rd_mode_o,
  input  logic          blk_locked_i,
  input  logic          vpp_ok_i,
  output logic          seq_start_o,
  output logic          seq_erase_o,
  output logic [AW-1:0] seq_addr_o,
  output logic [DW-1:0] seq_data_o,
  output logic          seq_suspend_o,
  output logic          seq_resume_o,
  input  logic          seq_done_i,
  input  logic          seq_fail_i,
  input  logic          seq_suspended_i
);
  rd_mode_e   mode;
  logic       running, suspended;
  err_ev_t    ev;
  logic [7:0] status;

  fcd_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .blk_locked_i, .vpp_ok_i, .seq_done_i, .seq_fail_i, .seq_suspended_i,
    .mode_o(mode), .running_o(running), .suspended_o(suspended),
    .seq_start_o, .seq_erase_o, .seq_addr_o, .seq_data_o,
    .seq_suspend_o, .seq_resume_o, .ev_o(ev)
  );

  fcd_status_reg u_status (
    .clk_i, .rst_ni, .ev_i(ev), .running_i(running),
    .suspended_i(suspended), .status_o(status)
  );

  fcd_read_mux #(.DW(DW)) u_mux (
    .mode_i(mode), .arr_i(arr_rdata_i), .id_i(id_rdata_i),
    .status_i(status), .rd_o(rd_data_o)
  );

  assign rd_mode_o = mode;

  assert_ready_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |-> !status[7]);
  assert_susp_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[2] |-> status[7]);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 20;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] arr_rdata = 8'hA5;
  logic [DW-1:0] id_rdata = 8'h89;
  logic [DW-1:0] rd_data;
  logic [1:0]    rd_mode;
  logic          blk_locked = 1'b0;
  logic          vpp_ok = 1'b1;
  logic          seq_start, seq_erase, seq_suspend, seq_resume;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;
  logic          seq_done = 1'b0;
  logic          seq_fail = 1'b0;
  logic          seq_susp = 1'b0;

  int errors = 0;
  int checks = 0;
  logic got_start, got_susp, got_res, got_erase;
  logic [AW-1:0] got_addr;
  logic [DW-1:0] got_data;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .arr_rdata_i(arr_rdata), .id_rdata_i(id_rdata),
    .rd_data_o(rd_data), .rd_mode_o(rd_mode), .blk_locked_i(blk_locked),
    .vpp_ok_i(vpp_ok), .seq_start_o(seq_start), .seq_erase_o(seq_erase),
    .seq_addr_o(seq_addr), .seq_data_o(seq_data), .seq_suspend_o(seq_suspend),
    .seq_resume_o(seq_resume), .seq_done_i(seq_done), .seq_fail_i(seq_fail),
    .seq_suspended_i(seq_susp)
  );

  // {write data, expected read data}
  localparam logic [15:0] VEC [8] = '{
    {8'h70, 8'h80}, {8'h90, 8'h89}, {8'hFF, 8'hA5}, {8'h20, 8'h80},
    {8'h33, 8'hB0}, {8'hFF, 8'hA5}, {8'h50, 8'hA5}, {8'h70, 8'h80}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    got_start = seq_start; got_susp = seq_suspend; got_res = seq_resume;
    got_erase = seq_erase; got_addr = seq_addr; got_data = seq_data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done(input logic f);
    @(negedge clk);
    seq_done = 1'b1; seq_fail = f;
    @(negedge clk);
    seq_done = 1'b0; seq_fail = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode", rd_mode, 0);
    check("R1 read", rd_data, 8'hA5);
    wr(0, 8'h70);
    check("R1 status", rd_data, 8'h80);
    wr(0, 8'hFF);

    // R2 R5 R11 table walk
    for (int i = 0; i < 8; i++) begin
      wr(0, VEC[i][15:8]);
      check("R2/R5/R11 vec", rd_data, VEC[i][7:0]);
    end

    // R3 program
    wr(20'h00012, 8'h40);
    check("R3 setup", rd_data, 8'h80);
    wr(20'h00012, 8'h3C);
    check("R3 start", got_start, 1);
    check("R3 kind", got_erase, 0);
    check("R3 addr", got_addr, 20'h00012);
    check("R3 data", got_data, 8'h3C);
    check("R9 busy", rd_data, 8'h00);
    wr(0, 8'hFF);
    check("R6 ignored FF", rd_data, 8'h00);
    wr(0, 8'h40);
    check("R6 no start", got_start, 0);
    done(1'b0);
    check("R9 done ok", rd_data, 8'h80);

    // R7 R8 suspend/resume
    wr(20'h00020, 8'h40);
    wr(20'h00020, 8'h55);
    wr(0, 8'hB0);
    check("R7 suspend req", got_susp, 1);
    check("R7 still busy", rd_data, 8'h00);
    @(negedge clk); seq_susp = 1'b1;
    @(negedge clk);
    check("R7 suspended", rd_data, 8'h84);
    wr(0, 8'h40);
    check("R8 ignored", rd_data, 8'h84);
    check("R8 no start", got_start, 0);
    wr(0, 8'hFF);
    check("R8 array", rd_data, 8'hA5);
    wr(0, 8'h90);
    check("R8 id", rd_data, 8'h89);
    wr(0, 8'hD0);
    check("R8 resume req", got_res, 1);
    check("R8 status after resume", rd_data, 8'h00);
    @(negedge clk); seq_susp = 1'b0;
    done(1'b1);
    check("R9 program fail", rd_data, 8'h90);
    wr(0, 8'hFF);
    wr(0, 8'h70);
    check("R11 sticky", rd_data, 8'h90);
    wr(0, 8'h50);
    check("R11 clear", rd_data, 8'h80);

    // R4 erase
    wr(0, 8'h20);
    wr(20'h00045, 8'hD0);
    check("R4 start", got_start, 1);
    check("R4 kind", got_erase, 1);
    check("R4 addr", got_addr, 20'h00045);
    wr(0, 8'hB0);
    check("R6 erase no suspend", got_susp, 0);
    check("R6 erase busy", rd_data, 8'h00);
    done(1'b1);
    check("R9 erase fail", rd_data, 8'hA0);
    wr(0, 8'h50);

    // R10 lock and voltage
    blk_locked = 1'b1;
    wr(0, 8'h40);
    wr(20'h00001, 8'hAA);
    check("R10 lock no start", got_start, 0);
    check("R10 lock bit", rd_data, 8'h82);
    blk_locked = 1'b0;
    wr(0, 8'h50);
    vpp_ok = 1'b0;
    wr(0, 8'h20);
    wr(0, 8'hD0);
    check("R10 vpp no start", got_start, 0);
    check("R10 vpp bit", rd_data, 8'h88);
    vpp_ok = 1'b1;
    wr(0, 8'h50);
    check("R11 clear again", rd_data, 8'h80);
    check("R12 idle requests", {seq_start, seq_suspend, seq_resume}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule